// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the stop condition for an I2C master after a byte transfer has finished. At that point the byte engine has left SCL low after the ninth clock. Software pulses a request, and the sequencer takes both lines low. It waits until it sees SDA low on the line. Then, with a reloadable baud down-counter timing each step, it releases SCL, waits until SCL is actually high, releases SDA, and confirms that both lines read high.

Both line outputs are open-drain pull enables: a 1 means the pin is driven low. Both line inputs pass through a two-stage synchronizer before any decision uses them. A slave that stretches SCL therefore holds the sequence at that step, because the counter is not reloaded until the expected level is seen. The block sets a stop-seen status bit that doubles as the bus-free indication. It raises a completion interrupt one baud period later and ends the busy indication at the same time. It also guards a data buffer: a write to the buffer during the sequence is dropped and a collision flag is set.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `stop_busy`, `stop_seen`, `done_irq` and `wr_collide` are 0, and `buf_q` is 0.
- R2: A `stop_req` pulse sampled while idle sets `stop_busy`, `sda_pull` and `scl_pull` to 1 on that same clock edge, and clears `stop_seen`.
- R3: With default parameters, `scl_pull` falls exactly `baud_reload`+4 cycles after the edge that accepted the request: 2 synchronizer cycles, 1 sampling cycle, and one baud period of `baud_reload`+1 cycles.
- R4: `sda_pull` falls exactly `baud_reload`+4 cycles after the SCL line input is first high following SCL release.
- R5: `stop_seen` rises exactly 3 cycles after `sda_pull` falls, given that SCL reads high.
- R6: Exactly `baud_reload`+1 cycles after `stop_seen` rises, `stop_busy` falls and `done_irq` rises on the same edge.
- R7: While a slave holds the SCL input low after release, `sda_pull` stays 1 and the sequence does not advance.
- R8: A `buf_wr` while `stop_busy` is 1 sets `wr_collide` on the next edge and leaves `buf_q` unchanged. A `buf_wr` while idle loads `buf_wdata` into `buf_q` and leaves `wr_collide` unchanged.
- R9: A `flag_clr` pulse clears `done_irq` and `wr_collide` on the next edge.
- R10: A `stop_req` while `stop_busy` is 1 is ignored: no output changes and the sequence timing is not altered.
- R11: `stop_seen` (bus free) stays 1 after completion and after `flag_clr`, until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Software pulse that starts the stop sequence |
| baud_reload | input | BRG_W | Baud counter reload; one period is reload+1 clocks |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | DATA_W | Data buffer write value |
| flag_clr | input | 1 | Clears completion and collision flags |
| scl_pull | output | 1 | 1 drives SCL low |
| sda_pull | output | 1 | 1 drives SDA low |
| stop_busy | output | 1 | Stop enable bit, cleared by hardware at completion |
| stop_seen | output | 1 | Stop detected, bus free |
| done_irq | output | 1 | Completion interrupt flag |
| wr_collide | output | 1 | Buffer write rejected during the sequence |
| buf_q | output | DATA_W | Data buffer contents |

## Verification
A wrong step state or a wrong counter value shows up first as a line pull that releases on the wrong edge. Every release instant is a fixed number of cycles after a visible cause, so a counter that is off by one moves `scl_pull` or `sda_pull` by one cycle, and that shift is caught within one baud period. A sampler that ignores the line level shows up during a held SCL as an early `sda_pull` release. Stale flag state shows up at the next buffer write or `flag_clr` as an unexpected `wr_collide` or `done_irq` edge.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULL_SDA,   // both lines pulled, wait for SDA low seen
    ST_TIME_SCL,   // one period, then release SCL
    ST_WAIT_SCL,   // wait for SCL high seen (stretch tolerant)
    ST_TIME_SDA,   // one period, then release SDA
    ST_WAIT_SDA,   // wait for both lines high
    ST_TIME_DONE   // one period after stop seen
  } stop_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;  // idle bus reads high
      else     sh <= {sh[STAGES-2:0], din[b]};
    end
    assign dout[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/i2c_stop_brg.sv
module i2c_stop_brg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic         zero
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= reload;
    else if (!zero) cnt <= cnt - 1'b1;
  end
  assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic [BRG_W-1:0]  baud_reload,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              flag_clr,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              stop_busy,
  output logic              stop_seen,
  output logic              done_irq,
  output logic              wr_collide,
  output logic [DATA_W-1:0] buf_q
);
  localparam int NLINES = 2;

  stop_state_e       state;
  logic [NLINES-1:0] line_s;
  logic              scl_s, sda_s, brg_load, brg_zero;

  i2c_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_stop_brg #(.W(BRG_W)) u_brg (
    .clk(clk), .rst(rst), .load(brg_load), .reload(baud_reload), .zero(brg_zero)
  );

  // The counter reloads only once the awaited line level is seen.
  always_comb begin
    case (state)
      ST_PULL_SDA: brg_load = !sda_s;
      ST_WAIT_SCL: brg_load = scl_s;
      ST_WAIT_SDA: brg_load = sda_s && scl_s;
      default:     brg_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      stop_busy <= 1'b0;
      stop_seen <= 1'b0;
      done_irq  <= 1'b0;
    end else begin
      if (flag_clr) done_irq <= 1'b0;
      case (state)
        ST_IDLE: if (stop_req) begin
          state     <= ST_PULL_SDA;
          sda_pull  <= 1'b1;
          scl_pull  <= 1'b1;
          stop_busy <= 1'b1;
          stop_seen <= 1'b0;
        end
        ST_PULL_SDA: if (brg_load) state <= ST_TIME_SCL;
        ST_TIME_SCL: if (brg_zero) begin
          scl_pull <= 1'b0;
          state    <= ST_WAIT_SCL;
        end
        ST_WAIT_SCL: if (brg_load) state <= ST_TIME_SDA;
        ST_TIME_SDA: if (brg_zero) begin
          sda_pull <= 1'b0;
          state    <= ST_WAIT_SDA;
        end
        ST_WAIT_SDA: if (brg_load) begin
          stop_seen <= 1'b1;
          state     <= ST_TIME_DONE;
        end
        ST_TIME_DONE: if (brg_zero) begin
          stop_busy <= 1'b0;
          done_irq  <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Data buffer with collision guard
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q      <= '0;
      wr_collide <= 1'b0;
    end else begin
      if (flag_clr) wr_collide <= 1'b0;
      if (buf_wr) begin
        if (stop_busy) wr_collide <= 1'b1;
        else           buf_q      <= buf_wdata;
      end
    end
  end

  a_r3_scl_after_sda: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_pull) |-> sda_pull);
  a_r4_sda_after_scl: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> !scl_pull);
  a_r5_seen_needs_lines: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_seen) |-> $past(sda_s && scl_s));
  a_r6_irq_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq) |-> !stop_busy && stop_seen);
  a_r7_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_SCL && !scl_s) |=> sda_pull);
  a_r8_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (buf_wr && stop_busy) |=> wr_collide && $stable(buf_q));
endmodule

// File: tb/i2c_stop_seq_bench.sv
module i2c_stop_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, buf_wr = 0, flag_clr = 0, hold_ln = 0;
  logic [7:0] baud_reload = 8'd3, buf_wdata = 8'd0;
  logic scl_in, sda_in;
  logic scl_pull, sda_pull, stop_busy, stop_seen, done_irq, wr_collide;
  logic [7:0] buf_q;

  always #4 clk = ~clk;  // 125 MHz

  assign scl_in = ~(scl_pull | hold_ln);
  assign sda_in = ~sda_pull;

  i2c_stop_seq u_i2c_stop_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .baud_reload(baud_reload),
    .scl_in(scl_in), .sda_in(sda_in), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .flag_clr(flag_clr), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .stop_busy(stop_busy), .stop_seen(stop_seen), .done_irq(done_irq),
    .wr_collide(wr_collide), .buf_q(buf_q)
  );

  int cyc = 0;
  int tests = 0, fails = 0;
  bit mon_on = 0, seen_m = 0, wcol_m = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // kinds: 0 sda_pull, 1 scl_pull, 2 stop_seen, 3 done_irq, 4 stop_busy, 5 wr_collide
  typedef struct { int t; int k; bit v; string req; } ev_t;
  ev_t q[$];

  function automatic void push(int t, int k, bit v, string req);
    ev_t e;
    int i = 0;
    e.t = t; e.k = k; e.v = v; e.req = req;
    while (i < q.size() && (q[i].t < t || (q[i].t == t && q[i].k <= k))) i++;
    q.insert(i, e);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: compare every output edge with the scoreboard queue
  initial begin
    logic [5:0] prev, cur;
    wait (mon_on);
    prev = {wr_collide, stop_busy, done_irq, stop_seen, scl_pull, sda_pull};
    forever begin
      @(negedge clk); #1;
      cur = {wr_collide, stop_busy, done_irq, stop_seen, scl_pull, sda_pull};
      while (q.size() > 0 && q[0].t < cyc) begin
        tests++; fails++;
        $display("FAIL %s: kind %0d actual no edge by %0d expected edge at %0d",
                 q[0].req, q[0].k, cyc, q[0].t);
        void'(q.pop_front());
      end
      for (int k = 0; k < 6; k++) begin
        if (cur[k] != prev[k]) begin
          tests++;
          if (q.size() == 0 || q[0].t != cyc || q[0].k != k || q[0].v != cur[k]) begin
            fails++;
            if (q.size() == 0)
              $display("FAIL R10: kind %0d actual edge to %0d at %0d expected no edge",
                       k, cur[k], cyc);
            else
              $display("FAIL %s: kind %0d actual edge to %0d at %0d expected kind %0d to %0d at %0d",
                       q[0].req, k, cur[k], cyc, q[0].k, q[0].v, q[0].t);
          end else void'(q.pop_front());
        end
      end
      prev = cur;
    end
  end

  // Driver: one stop sequence, with optional slave hold and mid-sequence pokes
  task automatic run_seq(int r, int hold, bit poke);
    int base, tscl, tline, tsda, tseen, tdone;
    logic [7:0] keep;
    @(negedge clk);
    baud_reload = 8'(r);
    hold_ln = (hold > 0);
    stop_req = 1;
    base = cyc + 1;
    tscl  = base + 4 + r;
    tline = tscl + hold;
    tsda  = tline + 4 + r;
    tseen = tsda + 3;
    tdone = tseen + r + 1;
    push(base, 0, 1, "R2");
    push(base, 1, 1, "R2");
    if (seen_m) push(base, 2, 0, "R11");
    push(base, 4, 1, "R2");
    push(tscl, 1, 0, "R3");
    push(tsda, 0, 0, hold > 0 ? "R7" : "R4");
    push(tseen, 2, 1, "R5");
    push(tdone, 3, 1, "R6");
    push(tdone, 4, 0, "R6");
    @(negedge clk);
    stop_req = 0;
    if (poke) begin
      keep = buf_q;
      buf_wr = 1; buf_wdata = ~keep;
      if (!wcol_m) push(cyc + 1, 5, 1, "R8");
      wcol_m = 1;
      @(negedge clk);
      buf_wr = 0;
      chk("R8", buf_q, keep);
      stop_req = 1;          // ignored while busy
      @(negedge clk);
      stop_req = 0;
    end
    if (hold > 0) begin
      wait_cyc(tline);
      hold_ln = 0;
    end
    wait_cyc(tdone + 2);
    seen_m = 1;
    chk("R11", stop_seen, 1);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1;
    push(cyc + 1, 3, 0, "R9");
    if (wcol_m) push(cyc + 1, 5, 0, "R9");
    wcol_m = 0;
    @(negedge clk);
    flag_clr = 0;
    @(negedge clk);
    chk("R11", stop_seen, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", scl_pull, 0);
    chk("R1", sda_pull, 0);
    chk("R1", stop_busy, 0);
    chk("R1", stop_seen, 0);
    chk("R1", done_irq, 0);
    chk("R1", wr_collide, 0);
    chk("R1", buf_q, 0);
    mon_on = 1;
    repeat (2) @(negedge clk);
    // idle write is accepted without collision (R8)
    buf_wr = 1; buf_wdata = 8'h5A;
    @(negedge clk);
    buf_wr = 0;
    chk("R8", buf_q, 8'h5A);
    run_seq(3, 0, 1);
    clear_flags();
    run_seq(0, 0, 0);
    clear_flags();
    run_seq(5, 9, 1);
    clear_flags();
    run_seq(10, 0, 0);
    repeat (5) @(negedge clk);
    chk("R9", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule